// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port that a processor controls through a small synchronous register bus. Software writes an output latch and a direction mask, and it may enable a pull-up on each pin. Software can read a pin view that returns the latched value on bits driven as outputs and the synchronized pad level on bits used as inputs. The port drives a per-bit pad output enable and output value, and it reports which pins currently request their pull-up.

A power-control state machine governs the registers. It has three states. `ST_RUN` is normal operation. `ST_SWSB` is software standby: all registers and the last read value are kept, the bus is shut, and the input synchronizer is frozen. `ST_HWSB` is hardware standby: every writable register is cleared, and it stays clear for as long as the request lasts.

The transitions are named as follows:
- `go_hw`: any state moves to `ST_HWSB` while `hw_stby_i` is high. This transition has priority over all others.
- `go_sw`: `ST_RUN` moves to `ST_SWSB` when `sw_stby_i` is high.
- `wake_sw`: `ST_SWSB` returns to `ST_RUN` when `sw_stby_i` falls.
- `wake_hw`: `ST_HWSB` returns to `ST_RUN` when `hw_stby_i` falls.

A mode input reduces the set of pull-ups that may take effect.

Top module: `gpio_port`

## Requirements
- R1: After reset, `pad_oe_o`, `pad_out_o`, `pull_en_o` and `rdata_o` are all 0x00.
- R2: A write to address 0 loads the output latch. `pad_out_o` shows the new value after the next clock edge, and a read of address 0 returns it.
- R3: A write to address 1 loads the direction mask, where 1 means output. `pad_oe_o` equals the mask after the next clock edge, and a read of address 1 returns it.
- R4: A read of address 2 returns, for each bit, the output latch bit if its direction bit is 1, and the pad level passed through two synchronizing flops if its direction bit is 0. A pin change is visible to a read strobe issued two cycles after the change. Writes to address 2 change no register.
- R5: Address 3 holds the pull-up register. When `mode_full_i` is 1, `pull_en_o` bit i is 1 exactly when pull-up bit i is 1 and direction bit i is 0.
- R6: When `mode_full_i` is 0, bits 4 to 0 of `pull_en_o` are forced to 0 and bits 7 to 5 follow R5. The stored pull-up register value is not affected by the mode.
- R7: `rdata_o` is registered. It takes the selected value on the clock edge where `rd_en_i` is high, and it holds its value when no read is accepted. Addresses 4 to 7 read as 0x00.
- R8: While `hw_stby_i` is high, the output latch, direction mask and pull-up register clear on each clock edge and writes are ignored. After release they read 0x00, and the pin view shows the pad levels.
- R9: While `sw_stby_i` is high (and `hw_stby_i` is low), registers keep their values, bus writes and reads are ignored, and the synchronizer holds its content. The first read after `wake_sw` returns the pin level captured before standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| hw_stby_i | input | 1 | Hardware standby request, clears registers |
| sw_stby_i | input | 1 | Software standby request, retains state |
| mode_full_i | input | 1 | 1: all pull-ups valid, 0: only bits 7..5 valid |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| pin_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Pad output enable per bit |
| pad_out_o | output | 8 | Pad output value per bit |
| pull_en_o | output | 8 | Pull-up request per bit |

## Verification
Register writes show on `pad_out_o`, `pad_oe_o` and `pull_en_o` one clock after the write edge, and read data appears one clock after the read strobe. The bench drives on the falling edge and samples at the next falling edge after the relevant rising edge. A pad change needs two rising edges to pass the synchronizer, so the bench waits two full cycles before it strobes a pin read. It also reads in the very first accepted cycle after `wake_sw` to expose the frozen synchronizer value. Hardware standby is held for several cycles and then checked after release, so the clear and the blocked writes are both observed through the bus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SWSB = 2'd1,
        ST_HWSB = 2'd2
    } pwr_state_t;

    localparam int unsigned REG_DATA = 0;
    localparam int unsigned REG_DIR  = 1;
    localparam int unsigned REG_PIN  = 2;
    localparam int unsigned REG_PULL = 3;
    localparam int unsigned REG_LAST = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             hold_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                stg[s] <= '0;
            end
        end else if (!hold_i) begin
            stg[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_pwr_fsm.sv
module gpio_pwr_fsm
    import gpio_port_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       hw_stby_i,
    input  logic       sw_stby_i,
    output pwr_state_t state_o,
    output logic       bus_ok_o,
    output logic       regs_clr_o,
    output logic       sync_hold_o
);

    pwr_state_t state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hw_stby_i)      state_d = ST_HWSB;   // go_hw
                else if (sw_stby_i) state_d = ST_SWSB;   // go_sw
            end
            ST_SWSB: begin
                if (hw_stby_i)       state_d = ST_HWSB;  // go_hw
                else if (!sw_stby_i) state_d = ST_RUN;   // wake_sw
            end
            ST_HWSB: begin
                if (!hw_stby_i)      state_d = ST_RUN;   // wake_hw
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        bus_ok_o    = 1'b0;
        regs_clr_o  = hw_stby_i;
        sync_hold_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                bus_ok_o    = !hw_stby_i && !sw_stby_i;
                sync_hold_o = sw_stby_i && !hw_stby_i;
            end
            ST_SWSB: begin
                sync_hold_o = sw_stby_i && !hw_stby_i;
            end
            ST_HWSB: begin
                sync_hold_o = 1'b0;
            end
            default: begin
                bus_ok_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned REDUCED_BITS = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              clr_i,
    input  logic              bus_ok_i,
    input  logic              mode_full_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  pin_sync_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  data_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  pull_en_o
);

    localparam int unsigned LOW_LIMIT = WIDTH - REDUCED_BITS;

    logic [WIDTH-1:0] data_q, dir_q, pull_q, rdata_q;
    logic [WIDTH-1:0] pin_view, rd_mux, valid_mask;
    logic             wr_ok, rd_ok;

    assign wr_ok = bus_ok_i && wr_en_i;
    assign rd_ok = bus_ok_i && rd_en_i;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
        end else if (wr_ok) begin
            if (addr_i == ADDR_W'(REG_DATA)) data_q <= wdata_i;
            if (addr_i == ADDR_W'(REG_DIR))  dir_q  <= wdata_i;
            if (addr_i == ADDR_W'(REG_PULL)) pull_q <= wdata_i;
        end
    end

    assign pin_view = (data_q & dir_q) | (pin_sync_i & ~dir_q);

    always_comb begin
        rd_mux = '0;
        if (addr_i == ADDR_W'(REG_DATA))      rd_mux = data_q;
        else if (addr_i == ADDR_W'(REG_DIR))  rd_mux = dir_q;
        else if (addr_i == ADDR_W'(REG_PIN))  rd_mux = pin_view;
        else if (addr_i == ADDR_W'(REG_PULL)) rd_mux = pull_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rdata_q <= '0;
        end else if (rd_ok) begin
            rdata_q <= rd_mux;
        end
    end

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_mask
        if (i >= int'(LOW_LIMIT)) begin : g_upper
            assign valid_mask[i] = 1'b1;
        end else begin : g_lower
            assign valid_mask[i] = mode_full_i;
        end
    end

    assign pull_en_o = pull_q & ~dir_q & valid_mask;
    assign data_o    = data_q;
    assign dir_o     = dir_q;
    assign rdata_o   = rdata_q;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned REDUCED_BITS = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              hw_stby_i,
    input  logic              sw_stby_i,
    input  logic              mode_full_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o,
    input  logic [WIDTH-1:0]  pin_i,
    output logic [WIDTH-1:0]  pad_oe_o,
    output logic [WIDTH-1:0]  pad_out_o,
    output logic [WIDTH-1:0]  pull_en_o
);

    pwr_state_t       pwr_state;
    logic             bus_ok, regs_clr, sync_hold;
    logic [WIDTH-1:0] pin_sync;

    gpio_pwr_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .hw_stby_i   (hw_stby_i),
        .sw_stby_i   (sw_stby_i),
        .state_o     (pwr_state),
        .bus_ok_o    (bus_ok),
        .regs_clr_o  (regs_clr),
        .sync_hold_o (sync_hold)
    );

    gpio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .hold_i  (sync_hold),
        .d_i     (pin_i),
        .q_o     (pin_sync)
    );

    gpio_regs #(
        .WIDTH        (WIDTH),
        .ADDR_W       (ADDR_W),
        .REDUCED_BITS (REDUCED_BITS)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .clr_i       (regs_clr),
        .bus_ok_i    (bus_ok),
        .mode_full_i (mode_full_i),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .wdata_i     (wdata_i),
        .pin_sync_i  (pin_sync),
        .rdata_o     (rdata_o),
        .data_o      (pad_out_o),
        .dir_o       (pad_oe_o),
        .pull_en_o   (pull_en_o)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned REDUCED_BITS = 3
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              hw_stby_i,
    input logic              sw_stby_i,
    input logic              mode_full_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [WIDTH-1:0]  wdata_i,
    input logic [WIDTH-1:0]  rdata_o,
    input logic [WIDTH-1:0]  pad_oe_o,
    input logic [WIDTH-1:0]  pad_out_o,
    input logic [WIDTH-1:0]  pull_en_o,
    input pwr_state_t        state
);

    localparam logic [WIDTH-1:0] LOW_MASK = WIDTH'((1 << (WIDTH - REDUCED_BITS)) - 1);

    logic acc;
    assign acc = (state == ST_RUN) && !hw_stby_i && !sw_stby_i;

    // R2
    data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (acc && wr_en_i && addr_i == ADDR_W'(REG_DATA)) |=> (pad_out_o == $past(wdata_i)));

    // R3
    dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (acc && wr_en_i && addr_i == ADDR_W'(REG_DIR)) |=> (pad_oe_o == $past(wdata_i)));

    // R6
    reduced_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !mode_full_i |-> ((pull_en_o & LOW_MASK) == '0));

    // R7
    unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (acc && rd_en_i && addr_i > ADDR_W'(REG_LAST)) |=> (rdata_o == '0));

    // R7
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !rd_en_i |=> $stable(rdata_o));

    // R8
    hw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hw_stby_i |=> (pad_oe_o == '0 && pad_out_o == '0 && pull_en_o == '0));

    // R9
    sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sw_stby_i && !hw_stby_i) |=> ($stable(pad_oe_o) && $stable(pad_out_o)));

endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH        (WIDTH),
    .ADDR_W       (ADDR_W),
    .REDUCED_BITS (REDUCED_BITS)
) u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .hw_stby_i   (hw_stby_i),
    .sw_stby_i   (sw_stby_i),
    .mode_full_i (mode_full_i),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .pad_oe_o    (pad_oe_o),
    .pad_out_o   (pad_out_o),
    .pull_en_o   (pull_en_o),
    .state       (pwr_state)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0, sw_stby = 1'b0, mode_full = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, pin = '0;
    logic [7:0] rdata, pad_oe, pad_out, pull_en;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    gpio_port u0 (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .hw_stby_i   (hw_stby),
        .sw_stby_i   (sw_stby),
        .mode_full_i (mode_full),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .pin_i       (pin),
        .pad_oe_o    (pad_oe),
        .pad_out_o   (pad_out),
        .pull_en_o   (pull_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pull_en", pull_en, 8'h00);
        check("R1 rdata", rdata, 8'h00);
    endtask

    task automatic t_data();
        logic [7:0] v;
        wr(3'd0, 8'hA5);
        check("R2 pad_out", pad_out, 8'hA5);
        rd(3'd0, v);
        check("R2 readback", v, 8'hA5);
        wr(3'd0, 8'h3C);
        check("R2 pad_out second", pad_out, 8'h3C);
        wr(3'd0, 8'hA5);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        wr(3'd1, 8'hF0);
        check("R3 pad_oe", pad_oe, 8'hF0);
        rd(3'd1, v);
        check("R3 readback", v, 8'hF0);
    endtask

    task automatic t_pin();
        logic [7:0] v;
        pin = 8'h3C;
        cyc(2);
        rd(3'd2, v);
        check("R4 mixed view", v, 8'hAC);
        pin = 8'hC3;
        cyc(2);
        rd(3'd2, v);
        check("R4 pin change", v, 8'hA3);
        wr(3'd2, 8'hFF);
        rd(3'd0, v);
        check("R4 write ignored data", v, 8'hA5);
        rd(3'd1, v);
        check("R4 write ignored dir", v, 8'hF0);
    endtask

    task automatic t_pull();
        mode_full = 1'b1;
        wr(3'd3, 8'hFF);
        check("R5 pull gated by dir", pull_en, 8'h0F);
        wr(3'd1, 8'h00);
        check("R5 pull all inputs", pull_en, 8'hFF);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        mode_full = 1'b0;
        cyc(1);
        check("R6 reduced mask", pull_en, 8'hE0);
        wr(3'd1, 8'h80);
        check("R6 reduced with dir", pull_en, 8'h60);
        rd(3'd3, v);
        check("R6 stored pull", v, 8'hFF);
        mode_full = 1'b1;
        cyc(1);
        check("R6 full restored", pull_en, 8'h7F);
    endtask

    task automatic t_bus();
        logic [7:0] v;
        rd(3'd5, v);
        check("R7 unmapped", v, 8'h00);
        rd(3'd0, v);
        check("R7 read data", v, 8'hA5);
        wr(3'd0, 8'h11);
        cyc(2);
        check("R7 rdata held", rdata, 8'hA5);
        rd(3'd7, v);
        check("R7 unmapped top", v, 8'h00);
    endtask

    task automatic t_sw();
        logic [7:0] v;
        wr(3'd0, 8'h5A);
        wr(3'd1, 8'h0F);
        pin = 8'h11;
        cyc(3);
        sw_stby = 1'b1;
        cyc(1);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        check("R9 pad_out kept", pad_out, 8'h5A);
        check("R9 pad_oe kept", pad_oe, 8'h0F);
        rd(3'd3, v);
        check("R9 read ignored", rdata, 8'h00);
        pin = 8'h22;
        cyc(3);
        sw_stby = 1'b0;
        cyc(1);
        rd(3'd2, v);
        check("R9 frozen sync", v, 8'h1A);
        cyc(2);
        rd(3'd2, v);
        check("R9 sync resumed", v, 8'h2A);
    endtask

    task automatic t_hw();
        logic [7:0] v;
        wr(3'd3, 8'h33);
        hw_stby = 1'b1;
        cyc(1);
        wr(3'd0, 8'h77);
        wr(3'd1, 8'h77);
        cyc(1);
        check("R8 pad_oe cleared", pad_oe, 8'h00);
        check("R8 pad_out cleared", pad_out, 8'h00);
        hw_stby = 1'b0;
        pin = 8'h96;
        cyc(3);
        rd(3'd0, v);
        check("R8 data zero", v, 8'h00);
        rd(3'd1, v);
        check("R8 dir zero", v, 8'h00);
        rd(3'd3, v);
        check("R8 pull zero", v, 8'h00);
        rd(3'd2, v);
        check("R8 pin view", v, 8'h96);
        check("R8 pull_en zero", pull_en, 8'h00);
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(1);
        t_data();
        t_dir();
        t_pin();
        t_pull();
        t_mode();
        t_bus();
        t_sw();
        t_hw();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule